// File: doc/BRIEF.md
# Occupancy-Ranked Dual-Thread Fetch Selector

This block decides which thread contexts may fetch instructions in the next cycle. The front end is several instructions wide and holds several contexts. Each cycle the block looks at every context and keeps only those that are active and not stalled. It ranks them by how many of their instructions are still waiting in the front end and issue queues, and it names two winners.

The context holding the fewest in-flight instructions goes first and may fill the whole fetch width. The runner-up receives only the slots the leader left empty. Starving a busy thread this way keeps the pipeline stocked with instructions from the threads that drain quickly.

Inputs are a per-context occupancy count, an active mask, a stall mask and a per-context supply count. The supply count is the number of instructions each context can deliver this cycle. Outputs are registered: two context identifiers, each with a valid bit and a slot grant. A two-flop synchronizer releases the asynchronous reset.

Top module: `fetch_pick2`

## Requirements
- R1: During reset and afterwards until the first update, both valid outputs are 0, both identifiers are 0 and both grants are 0.
- R2: A context is eligible only when its active bit is 1 and its stall bit is 0. With no eligible context, both valids are 0, and both identifiers and both grants read 0.
- R3: The first pick is the eligible context with the smallest occupancy count. Equal counts go to the lower context index.
- R4: The second pick is chosen by the same ranking and tie rule among the eligible contexts other than the first pick.
- R5: The first grant equals the first pick's supply count, limited to the fetch width of 8.
- R6: The second grant equals the smaller of (8 minus the first grant) and the second pick's supply count. The two grants never sum above 8.
- R7: With exactly one eligible context, the second valid is 0, and the second identifier and second grant read 0.
- R8: Outputs change one clock after the inputs they reflect. They are sampled on the rising edge.
- R9: A context that is not eligible is never named in either pick, however low its occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| occ_i | input | 56 | Occupancy count per context, 7 bits each, context k at bits [7k+6:7k] |
| active_i | input | 8 | Context active mask, bit k for context k |
| stall_i | input | 8 | Context stalled on a miss, bit k for context k |
| supply_i | input | 32 | Instructions available per context, 4 bits each, context k at bits [4k+3:4k] |
| first_vld_o | output | 1 | First pick is valid |
| first_id_o | output | 3 | First pick context index |
| first_grant_o | output | 4 | Slots granted to first pick |
| second_vld_o | output | 1 | Second pick is valid |
| second_id_o | output | 3 | Second pick context index |
| second_grant_o | output | 4 | Slots granted to second pick |

## Verification
Random occupancy, mask and supply patterns try the ranking against many eligible sets. They distinguish a wrong minimum from a wrong exclusion of the first pick. Directed cases with all counts equal separate the lower-index tie rule from any other order. A stalled context carrying the lowest count shows whether eligibility is applied before ranking. Supply values above the width, a first supply of zero, and single or empty eligible sets exercise the grant arithmetic and the lone-winner and no-winner outputs.

// File: rtl/fetch_pick2_pkg.sv
package fetch_pick2_pkg;
  parameter int unsigned NCTX  = 8;
  parameter int unsigned FW    = 8;
  parameter int unsigned OCC_W = 7;
  localparam int unsigned IDW  = $clog2(NCTX);
  localparam int unsigned SLW  = $clog2(FW + 1);

  typedef struct packed {
    logic           v0;
    logic [IDW-1:0] id0;
    logic [SLW-1:0] g0;
    logic           v1;
    logic [IDW-1:0] id1;
    logic [SLW-1:0] g1;
  } pick_t;
endpackage

// File: rtl/fetch_pick2_min.sv
module fetch_pick2_min
  import fetch_pick2_pkg::*;
(
  input  logic [NCTX*OCC_W-1:0] occ_i,
  input  logic [NCTX-1:0]       mask_i,
  output logic                  found_o,
  output logic [IDW-1:0]        idx_o
);
  logic [OCC_W-1:0] best;

  // Strict less-than while scanning upward keeps the lower index on ties.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int k = 0; k < int'(NCTX); k++) begin
      if (mask_i[k] && (!found_o || occ_i[k*OCC_W +: OCC_W] < best)) begin
        found_o = 1'b1;
        idx_o   = IDW'(k);
        best    = occ_i[k*OCC_W +: OCC_W];
      end
    end
  end
endmodule

// File: rtl/fetch_pick2_slots.sv
module fetch_pick2_slots
  import fetch_pick2_pkg::*;
(
  input  logic           v0_i,
  input  logic           v1_i,
  input  logic [SLW-1:0] sup0_i,
  input  logic [SLW-1:0] sup1_i,
  output logic [SLW-1:0] g0_o,
  output logic [SLW-1:0] g1_o
);
  logic [SLW-1:0] left;

  always_comb begin
    g0_o = '0;
    if (v0_i) g0_o = (sup0_i > SLW'(FW)) ? SLW'(FW) : sup0_i;
    left = SLW'(FW) - g0_o;
    g1_o = '0;
    if (v1_i) g1_o = (sup1_i > left) ? left : sup1_i;
  end
endmodule

// File: rtl/fetch_pick2.sv
module fetch_pick2
  import fetch_pick2_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic [NCTX*OCC_W-1:0] occ_i,
  input  logic [NCTX-1:0]       active_i,
  input  logic [NCTX-1:0]       stall_i,
  input  logic [NCTX*SLW-1:0]   supply_i,
  output logic                  first_vld_o,
  output logic [IDW-1:0]        first_id_o,
  output logic [SLW-1:0]        first_grant_o,
  output logic                  second_vld_o,
  output logic [IDW-1:0]        second_id_o,
  output logic [SLW-1:0]        second_grant_o
);
  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [NCTX-1:0] elig, elig2;
  logic            f0, f1;
  logic [IDW-1:0]  i0, i1;
  logic [SLW-1:0]  g0, g1;
  logic            upd_en;
  pick_t           nxt, cur;

  // Reset asserts at once and releases after two clocks.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= '0;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign elig = active_i & ~stall_i;

  fetch_pick2_min u_min0 (.occ_i(occ_i), .mask_i(elig),  .found_o(f0), .idx_o(i0));

  always_comb begin
    elig2 = elig;
    elig2[i0] = 1'b0;
  end

  fetch_pick2_min u_min1 (.occ_i(occ_i), .mask_i(elig2), .found_o(f1), .idx_o(i1));

  fetch_pick2_slots u_slots (
    .v0_i  (f0),
    .v1_i  (f1),
    .sup0_i(supply_i[i0*SLW +: SLW]),
    .sup1_i(supply_i[i1*SLW +: SLW]),
    .g0_o  (g0),
    .g1_o  (g1)
  );

  always_comb begin
    nxt.v0  = f0;
    nxt.id0 = f0 ? i0 : '0;
    nxt.g0  = g0;
    nxt.v1  = f1;
    nxt.id1 = f1 ? i1 : '0;
    nxt.g1  = g1;
  end

  // A selection is made every cycle.
  assign upd_en = 1'b1;

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q)      cur <= '0;
    else if (upd_en) cur <= nxt;
  end

  assign first_vld_o    = cur.v0;
  assign first_id_o     = cur.id0;
  assign first_grant_o  = cur.g0;
  assign second_vld_o   = cur.v1;
  assign second_id_o    = cur.id1;
  assign second_grant_o = cur.g1;
endmodule

// File: rtl/fetch_pick2_chk.sv
module fetch_pick2_chk
  import fetch_pick2_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_q,
  input logic [NCTX-1:0]       active_i,
  input logic [NCTX-1:0]       stall_i,
  input logic [NCTX*OCC_W-1:0] occ_i,
  input logic                  first_vld_o,
  input logic [IDW-1:0]        first_id_o,
  input logic [SLW-1:0]        first_grant_o,
  input logic                  second_vld_o,
  input logic [IDW-1:0]        second_id_o,
  input logic [SLW-1:0]        second_grant_o
);
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_q)
    (first_grant_o + second_grant_o) <= SLW'(FW));

  a_r7_second_needs_first: assert property (@(posedge clk_i) disable iff (!rst_q)
    second_vld_o |-> first_vld_o);

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_q)
    !second_vld_o |-> (second_grant_o == '0));

  a_r4_distinct: assert property (@(posedge clk_i) disable iff (!rst_q)
    second_vld_o |-> (first_id_o != second_id_o));

  a_r2_any_eligible: assert property (@(posedge clk_i) disable iff (!rst_q)
    1'b1 |=> (first_vld_o == $past(|(active_i & ~stall_i))));

  a_r9_first_eligible: assert property (@(posedge clk_i) disable iff (!rst_q)
    1'b1 |=> (!first_vld_o || $past(active_i & ~stall_i) >> first_id_o & 1));

  a_r3_order: assert property (@(posedge clk_i) disable iff (!rst_q)
    1'b1 |=> (!second_vld_o ||
      ($past(occ_i) >> (first_id_o*OCC_W) & {OCC_W{1'b1}}) <=
      ($past(occ_i) >> (second_id_o*OCC_W) & {OCC_W{1'b1}})));
endmodule

bind fetch_pick2 fetch_pick2_chk u_chk (
  .clk_i(clk_i), .rst_q(rst_q), .active_i(active_i), .stall_i(stall_i), .occ_i(occ_i),
  .first_vld_o(first_vld_o), .first_id_o(first_id_o), .first_grant_o(first_grant_o),
  .second_vld_o(second_vld_o), .second_id_o(second_id_o), .second_grant_o(second_grant_o)
);

// File: tb/fetch_pick2_tb.sv
`timescale 1ns/1ps
module fetch_pick2_tb_top;
  localparam int N = 8;
  localparam int OW = 7;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N*OW-1:0] occ;
  logic [N-1:0]  act, stl;
  logic [N*SW-1:0] sup;
  logic          v0, v1;
  logic [2:0]    id0, id1;
  logic [3:0]    g0, g1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fetch_pick2 dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .occ_i(occ), .active_i(act), .stall_i(stl),
    .supply_i(sup), .first_vld_o(v0), .first_id_o(id0), .first_grant_o(g0),
    .second_vld_o(v1), .second_id_o(id1), .second_grant_o(g1)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // Model: picks the lowest count among eligible, lower index on ties.
  task automatic expect_now(output int e_v0, output int e_i0, output int e_g0,
                            output int e_v1, output int e_i1, output int e_g1);
    logic [N-1:0] el;
    int best;
    el = act & ~stl;
    e_v0 = 0; e_i0 = 0; e_v1 = 0; e_i1 = 0; e_g0 = 0; e_g1 = 0;
    best = 1000;
    for (int k = 0; k < N; k++)
      if (el[k] && int'(occ[k*OW +: OW]) < best) begin
        best = int'(occ[k*OW +: OW]); e_i0 = k; e_v0 = 1;
      end
    best = 1000;
    for (int k = 0; k < N; k++)
      if (el[k] && !(e_v0 == 1 && k == e_i0) && int'(occ[k*OW +: OW]) < best) begin
        best = int'(occ[k*OW +: OW]); e_i1 = k; e_v1 = 1;
      end
    if (e_v0 == 1) e_g0 = (int'(sup[e_i0*SW +: SW]) > 8) ? 8 : int'(sup[e_i0*SW +: SW]);
    if (e_v1 == 1) e_g1 = (int'(sup[e_i1*SW +: SW]) > 8 - e_g0) ? 8 - e_g0 : int'(sup[e_i1*SW +: SW]);
  endtask

  // Inputs are set away from the edge; outputs are read 1 ns after the capturing edge (R8).
  task automatic apply(input string tag);
    int a, b, c, d, e, f;
    expect_now(a, b, c, d, e, f);
    @(posedge clk); #1;
    chk({tag, " R8 R2 first valid"}, int'(v0), a);
    chk({tag, " R3 R9 first id"}, int'(id0), b);
    chk({tag, " R5 first grant"}, int'(g0), c);
    chk({tag, " R4 R7 second valid"}, int'(v1), d);
    chk({tag, " R4 R9 second id"}, int'(id1), e);
    chk({tag, " R6 second grant"}, int'(g1), f);
  endtask

  task automatic set_all(input int o, input int s);
    for (int k = 0; k < N; k++) begin
      occ[k*OW +: OW] = OW'(o);
      sup[k*SW +: SW] = SW'(s);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    act = '1; stl = '0;
    set_all(5, 4);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset first valid", int'(v0), 0);
    chk("R1 reset second valid", int'(v1), 0);
    chk("R1 reset grants", int'(g0) + int'(g1), 0);
    chk("R1 reset ids", int'(id0) + int'(id1), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R3 ties: all equal counts -> contexts 0 and 1
    act = '1; stl = '0; set_all(9, 5);
    apply("tie");
    // R2: no eligible context
    act = 8'hF0; stl = 8'hF0;
    apply("R2 none eligible");
    // R7: single eligible
    act = 8'h20; stl = '0;
    apply("R7 single");
    // R9: stalled context has lowest count
    act = '1; stl = 8'h08; set_all(40, 6); occ[3*OW +: OW] = 0; occ[6*OW +: OW] = 2;
    apply("R9 stalled lowest");
    // R5: supply above width
    stl = '0; sup[3*SW +: SW] = 15;
    apply("R5 cap");
    // R6: first supplies 3, second 9
    sup[3*SW +: SW] = 3; sup[6*SW +: SW] = 9;
    apply("R6 leftover");
    // R6: first supplies 0
    sup[3*SW +: SW] = 0; sup[6*SW +: SW] = 7;
    apply("R6 zero first");
    // R4: second decided by tie among the rest
    set_all(20, 4); occ[5*OW +: OW] = 1;
    apply("R4 second tie");

    for (int n = 0; n < 400; n++) begin
      act = N'($urandom);
      stl = N'($urandom) & N'($urandom);
      for (int k = 0; k < N; k++) begin
        occ[k*OW +: OW] = OW'($urandom_range(0, (n % 3 == 0) ? 3 : 127));
        sup[k*SW +: SW] = SW'($urandom_range(0, 15));
      end
      apply("rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule